// File: doc/BRIEF.md
# Predicated Result Select with Fallback

This block sits at the end of an execution pipe and applies per-element predication to a computed result. A 128-bit lane is split into elements whose size follows the operand type code. Each element takes its predicate and option bits from a matching slice of a mask vector. That vector is either a selected mask register value or, when the mask selector holds 7, the numeric control register copied into every element with its bit 0 forced to 1.

An enabled element passes the computed result through. A disabled element raises its error-suppress flag and, for a register destination, takes the fallback register value instead; fallback register 31 stands for the constant zero. For a memory store there is no fallback: the result passes through unchanged and the byte write enables of disabled elements drop, so memory keeps its old contents.

Every output flag is given per byte, replicated across the bytes of its element. The same holds for the rounding mode (element bits 10..12) and the high option field (element bits 18..23). A parameter chooses between a purely combinational path and one output register stage.

Top module: `pred_select`

## Requirements
- R1: With mask_sel_i in 0..6 the mask vector is mask_val_i. With mask_sel_i = 7 the mask vector comes from ctrl_val_i, and mask_val_i has no effect on any output.
- R2: An element is enabled exactly when bit 0 of its mask element is 1. For a disabled element, err_supp_o is 1 on all its bytes, and for a non-store its dest_o bytes equal the fallback value. For an enabled element, err_supp_o is 0 and dest_o equals result_i.
- R3: The element size in bytes comes from op_type_i as follows: 0→1, 1→2, 2→4, 3→8, 4→16, 5→4, 6→8, 7→16. Element k covers lane bytes k·size to k·size+size−1, and byte i of the lane is bits 8i+7..8i.
- R4: With mask_sel_i = 7, each element receives ctrl_val_i truncated to the element width, with its upper bits zero-filled. Bit 0 of each element is forced to 1, so every element is enabled.
- R5: If fb_reg_i = 31, the fallback value is zero and fb_val_i is not used.
- R6: With is_store_i = 1, dest_o equals result_i and byte_we_o[i] is 1 only for bytes of enabled elements. With is_store_i = 0, all byte_we_o bits are 1.
- R7: opt_hi_o[6i+5:6i] carries bits 23..18 of the mask element that holds byte i. It is zero whenever op_type_i is 0 or 1.
- R8: round_mode_o[3i+2:3i] carries bits 12..10 of the mask element that holds byte i. The codes are 000 nearest-even, 001 down, 010 up and 011 toward zero.
- R9: With REG_OUT = 1, outputs appear one clock after the inputs, and an active-low reset clears every output to zero. With REG_OUT = 0 the path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low reset, clears the output stage |
| mask_sel_i | input | 3 | Mask selector; 7 means no mask register |
| mask_val_i | input | LANE_W | Value of the selected mask register |
| ctrl_val_i | input | CTRL_W | Numeric control register value |
| op_type_i | input | 3 | Operand type code, sets the element size |
| result_i | input | LANE_W | Computed result |
| fb_reg_i | input | 5 | Fallback register number |
| fb_val_i | input | LANE_W | Fallback register contents |
| is_store_i | input | 1 | Destination is memory |
| dest_o | output | LANE_W | Final destination value |
| byte_we_o | output | LANE_W/8 | Per-byte write enables |
| err_supp_o | output | LANE_W/8 | Per-byte error-suppress flags |
| round_mode_o | output | 3·LANE_W/8 | Per-byte rounding mode |
| opt_hi_o | output | 6·LANE_W/8 | Per-byte high option bits |

## Verification
Store handling and the zero fallback can both apply in the same cycle. A store with a fully disabled 16-byte element and fallback register 31 provokes this. It is judged correct only if dest_o still carries result_i, rather than zeros, while every byte write enable is low. A second overlap is tested by running the no-mask broadcast together with a 16-bit element size. Here the rounding field must survive while the high option bits read zero, and bytes at odd offsets must stay enabled even though the forced bit sits only in byte 0 of each element.

// File: rtl/prs_pkg.sv
package prs_pkg;

    localparam int          RND_LSB   = 10;
    localparam int          XOPT_LSB  = 18;
    localparam int          RND_W     = 3;
    localparam int          XOPT_W    = 6;
    localparam int          ELEM_BITS = 24;   // lowest mask bits any output needs
    localparam logic [2:0]  NOMASK    = 3'd7;
    localparam logic [4:0]  ZERO_REG  = 5'd31;

    // log2 of the element size in bytes for each operand type code
    function automatic int elem_log2(input logic [2:0] ot);
        int r;
        unique case (ot)
            3'd0:    r = 0;
            3'd1:    r = 1;
            3'd2:    r = 2;
            3'd3:    r = 3;
            3'd4:    r = 4;
            3'd5:    r = 2;
            3'd6:    r = 3;
            3'd7:    r = 4;
            default: r = 0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/prs_mask_build.sv
module prs_mask_build
    import prs_pkg::*;
#(
    parameter int LANE_W = 128,
    parameter int CTRL_W = 32
) (
    input  logic [2:0]        sel_i,
    input  logic [LANE_W-1:0] mask_val_i,
    input  logic [CTRL_W-1:0] ctrl_val_i,
    input  logic [2:0]        op_type_i,
    output logic [LANE_W-1:0] eff_mask_o
);
    localparam int NB = LANE_W / 8;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        int                off;
        logic [CTRL_W-1:0] shifted;
        logic [7:0]        bcast;

        // byte offset inside its element picks the control byte; past the
        // control width the shift leaves zeros
        always_comb begin
            off     = i & ((1 << elem_log2(op_type_i)) - 1);
            shifted = ctrl_val_i >> (off * 8);
            bcast   = shifted[7:0];
            if (off == 0) bcast[0] = 1'b1;
        end

        assign eff_mask_o[i*8 +: 8] = (sel_i == NOMASK) ? bcast
                                                        : mask_val_i[i*8 +: 8];
    end

endmodule

// File: rtl/prs_lane.sv
module prs_lane
    import prs_pkg::*;
#(
    parameter int LANE_W = 128,
    parameter int IDX    = 0
) (
    input  logic [LANE_W-1:0] eff_mask_i,
    input  logic [2:0]        op_type_i,
    input  logic              is_store_i,
    input  logic [7:0]        res_i,
    input  logic [7:0]        fb_i,
    output logic [7:0]        dest_o,
    output logic              we_o,
    output logic              supp_o,
    output logic [RND_W-1:0]  rnd_o,
    output logic [XOPT_W-1:0] xopt_o
);
    localparam int IW = $clog2(LANE_W);

    int                   sz;
    int                   base;
    logic [ELEM_BITS-1:0] ebits;
    logic                 en;

    always_comb begin
        sz    = 1 << elem_log2(op_type_i);
        base  = IDX & ~(sz - 1);
        ebits = '0;
        for (int k = 0; k < ELEM_BITS; k++) begin
            if ((k / 8) < sz) ebits[k] = eff_mask_i[IW'(base * 8 + k)];
        end
        en     = ebits[0];
        supp_o = !en;
        we_o   = is_store_i ? en : 1'b1;
        dest_o = (en || is_store_i) ? res_i : fb_i;
        rnd_o  = ebits[RND_LSB +: RND_W];
        xopt_o = (op_type_i <= 3'd1) ? '0 : ebits[XOPT_LSB +: XOPT_W];
    end

endmodule

// File: rtl/prs_out_stage.sv
module prs_out_stage #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_o <= '0;
            else        q_o <= d_i;
        end
    end else begin : g_wire
        assign q_o = d_i;
    end

endmodule

// File: rtl/pred_select.sv
module pred_select
    import prs_pkg::*;
#(
    parameter int LANE_W  = 128,
    parameter int CTRL_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 mask_sel_i,
    input  logic [LANE_W-1:0]          mask_val_i,
    input  logic [CTRL_W-1:0]          ctrl_val_i,
    input  logic [2:0]                 op_type_i,
    input  logic [LANE_W-1:0]          result_i,
    input  logic [4:0]                 fb_reg_i,
    input  logic [LANE_W-1:0]          fb_val_i,
    input  logic                       is_store_i,
    output logic [LANE_W-1:0]          dest_o,
    output logic [LANE_W/8-1:0]        byte_we_o,
    output logic [LANE_W/8-1:0]        err_supp_o,
    output logic [RND_W*LANE_W/8-1:0]  round_mode_o,
    output logic [XOPT_W*LANE_W/8-1:0] opt_hi_o
);
    localparam int NB    = LANE_W / 8;
    localparam int BUS_W = LANE_W + 2 * NB + (RND_W + XOPT_W) * NB;

    logic [LANE_W-1:0]        eff_mask;
    logic [LANE_W-1:0]        fb_eff;
    logic [LANE_W-1:0]        c_dest;
    logic [NB-1:0]            c_we;
    logic [NB-1:0]            c_supp;
    logic [RND_W*NB-1:0]      c_rnd;
    logic [XOPT_W*NB-1:0]     c_xopt;
    logic [BUS_W-1:0]         c_bus;
    logic [BUS_W-1:0]         q_bus;

    prs_mask_build #(.LANE_W(LANE_W), .CTRL_W(CTRL_W)) u_mask (
        .sel_i      (mask_sel_i),
        .mask_val_i (mask_val_i),
        .ctrl_val_i (ctrl_val_i),
        .op_type_i  (op_type_i),
        .eff_mask_o (eff_mask)
    );

    assign fb_eff = (fb_reg_i == ZERO_REG) ? '0 : fb_val_i;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        prs_lane #(.LANE_W(LANE_W), .IDX(i)) u_lane (
            .eff_mask_i (eff_mask),
            .op_type_i  (op_type_i),
            .is_store_i (is_store_i),
            .res_i      (result_i[i*8 +: 8]),
            .fb_i       (fb_eff[i*8 +: 8]),
            .dest_o     (c_dest[i*8 +: 8]),
            .we_o       (c_we[i]),
            .supp_o     (c_supp[i]),
            .rnd_o      (c_rnd[i*RND_W +: RND_W]),
            .xopt_o     (c_xopt[i*XOPT_W +: XOPT_W])
        );
    end

    assign c_bus = {c_dest, c_we, c_supp, c_rnd, c_xopt};

    prs_out_stage #(.W(BUS_W), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (c_bus),
        .q_o   (q_bus)
    );

    assign {dest_o, byte_we_o, err_supp_o, round_mode_o, opt_hi_o} = q_bus;

    // checks on the lane outputs against the block inputs
    AST_STORE_WE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        is_store_i |-> (c_we == ~c_supp));                                        // R6
    AST_REG_WE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !is_store_i |-> (&c_we));                                                 // R6
    AST_NOMASK_FIRST_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_sel_i == NOMASK) |-> (c_supp == '0));                               // R4
    AST_FB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_store_i && fb_reg_i == ZERO_REG && c_supp[0]) |-> (c_dest[7:0] == 8'h00)); // R5
    AST_SMALL_XOPT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_type_i <= 3'd1) |-> (c_xopt == '0));                                  // R7

endmodule

// File: tb/pred_select_bench.sv
module pred_select_bench;
    localparam int LW = 128;
    localparam int NB = LW / 8;

    typedef struct packed {
        logic [2:0]    sel;
        logic [LW-1:0] mask;
        logic [31:0]   ctrl;
        logic [2:0]    op;
        logic [4:0]    fbr;
        logic          st;
        logic [NB-1:0] exp_supp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // R3 byte elements, alternating enables
        '{3'd0, {8{16'h0001}}, 32'h0, 3'd0, 5'd3, 1'b0, 16'hAAAA},
        // 32-bit elements, fallback reg 31 gives zero (R5)
        '{3'd2, {32'h2, 32'h3, 32'h0, 32'h1}, 32'h0, 3'd2, 5'd31, 1'b0, 16'hF0F0},
        // R1 R4 no mask, 64-bit, mask register ignored; round up, high opts set
        '{3'd7, {LW{1'b1}} ^ {LW{1'b1}}, 32'h00FC_0800, 3'd3, 5'd2, 1'b0, 16'h0000},
        // no mask, byte elements: upper control bits truncated away
        '{3'd7, {16{8'hF0}}, 32'h00FC_0800, 3'd0, 5'd2, 1'b0, 16'h0000},
        // no mask, 16-bit elements: round survives, high opts zero (R7)
        '{3'd7, {16{8'hF0}}, 32'h00FC_0800, 3'd1, 5'd2, 1'b0, 16'h0000},
        // store, 128-bit element disabled, fallback reg 31 (R6 with R5)
        '{3'd1, {LW{1'b0}}, 32'h0, 3'd4, 5'd31, 1'b1, 16'hFFFF},
        // store, double elements, low one disabled, round toward zero (R8)
        '{3'd4, {64'h1, 64'h0C00}, 32'h0, 3'd6, 5'd7, 1'b1, 16'h00FF},
        // float elements, alternating
        '{3'd5, {32'h0, 32'h1, 32'h0, 32'h1}, 32'h0, 3'd5, 5'd31, 1'b0, 16'hF0F0},
        // no mask, 128-bit element, only high opts
        '{3'd7, {LW{1'b0}}, 32'h00FC_0000, 3'd4, 5'd9, 1'b0, 16'h0000}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      mask_sel_i = '0;
    logic [LW-1:0]   mask_val_i = '0;
    logic [31:0]     ctrl_val_i = '0;
    logic [2:0]      op_type_i = '0;
    logic [LW-1:0]   result_i = '0;
    logic [4:0]      fb_reg_i = '0;
    logic [LW-1:0]   fb_val_i = '0;
    logic            is_store_i = 1'b0;
    logic [LW-1:0]   dest_o;
    logic [NB-1:0]   byte_we_o;
    logic [NB-1:0]   err_supp_o;
    logic [3*NB-1:0] round_mode_o;
    logic [6*NB-1:0] opt_hi_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    pred_select #(.LANE_W(LW), .CTRL_W(32), .REG_OUT(1'b1)) u_pred_select (
        .clk, .rst_n, .mask_sel_i, .mask_val_i, .ctrl_val_i, .op_type_i,
        .result_i, .fb_reg_i, .fb_val_i, .is_store_i,
        .dest_o, .byte_we_o, .err_supp_o, .round_mode_o, .opt_hi_o
    );

    task automatic check(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] res_pat();
        logic [LW-1:0] r;
        for (int i = 0; i < NB; i++) r[i*8 +: 8] = 8'h10 + 8'(i);
        return r;
    endfunction

    function automatic logic [LW-1:0] fb_pat();
        logic [LW-1:0] r;
        for (int i = 0; i < NB; i++) r[i*8 +: 8] = 8'hC0 ^ 8'(i);
        return r;
    endfunction

    // independent model written from the requirements
    task automatic model(input vec_t v, output logic [LW-1:0] d, output logic [NB-1:0] we,
                         output logic [NB-1:0] sp, output logic [3*NB-1:0] rm,
                         output logic [6*NB-1:0] xo);
        int esz;
        logic [LW-1:0] rs, fb;
        rs = res_pat();
        fb = fb_pat();
        case (v.op)
            3'd0: esz = 1;   3'd1: esz = 2;   3'd2: esz = 4;   3'd3: esz = 8;
            3'd4: esz = 16;  3'd5: esz = 4;   3'd6: esz = 8;   default: esz = 16;
        endcase
        for (int e = 0; e < NB / esz; e++) begin
            logic [23:0] eb;
            eb = '0;
            for (int k = 0; k < 24; k++)
                if (k < esz * 8) eb[k] = (v.sel == 3'd7) ? v.ctrl[k] : v.mask[e*esz*8 + k];
            if (v.sel == 3'd7) eb[0] = 1'b1;
            for (int b = 0; b < esz; b++) begin
                int ix;
                ix = e * esz + b;
                sp[ix] = !eb[0];
                we[ix] = v.st ? eb[0] : 1'b1;
                if (eb[0] || v.st)       d[ix*8 +: 8] = rs[ix*8 +: 8];
                else if (v.fbr == 5'd31) d[ix*8 +: 8] = 8'h00;
                else                     d[ix*8 +: 8] = fb[ix*8 +: 8];
                rm[ix*3 +: 3] = eb[12:10];
                xo[ix*6 +: 6] = (v.op <= 3'd1) ? 6'h0 : eb[23:18];
            end
        end
    endtask

    task automatic drive(input vec_t v);
        mask_sel_i = v.sel;  mask_val_i = v.mask;  ctrl_val_i = v.ctrl;
        op_type_i  = v.op;   fb_reg_i   = v.fbr;   is_store_i = v.st;
        result_i   = res_pat();  fb_val_i = fb_pat();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [LW-1:0]   d;
        logic [NB-1:0]   we, sp;
        logic [3*NB-1:0] rm;
        logic [6*NB-1:0] xo;

        // R9 reset state with live inputs
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        check("R9 reset dest", dest_o, '0);
        check("R9 reset we", LW'(byte_we_o), '0);
        check("R9 reset opts", LW'({round_mode_o, opt_hi_o}), '0);
        rst_n = 1'b1;

        for (int n = 0; n < NV; n++) begin
            @(negedge clk);
            drive(VECS[n]);
            @(negedge clk);
            model(VECS[n], d, we, sp, rm, xo);
            check("R1 R2 R3 R4 supp table", LW'(err_supp_o), LW'(VECS[n].exp_supp));
            check("R2 R3 supp model", LW'(err_supp_o), LW'(sp));
            check("R2 R5 dest", dest_o, d);
            check("R6 byte_we", LW'(byte_we_o), LW'(we));
            check("R8 round", LW'(round_mode_o), LW'(rm));
            check("R7 opt_hi", LW'(opt_hi_o), LW'(xo));
        end

        // R1: mask register contents change under no-mask select, outputs unchanged
        @(negedge clk);
        drive(VECS[2]);
        mask_val_i = {LW{1'b1}} ^ {32{4'h5}};
        @(negedge clk);
        model(VECS[2], d, we, sp, rm, xo);
        check("R1 ignored mask dest", dest_o, d);
        check("R1 ignored mask supp", LW'(err_supp_o), LW'(sp));

        // R5: fallback reg 30 uses the register value, not zero
        @(negedge clk);
        drive(VECS[1]);
        fb_reg_i = 5'd30;
        @(negedge clk);
        check("R5 reg30 fallback", dest_o[39:32], 8'hC0 ^ 8'd4);

        // R9: one-cycle latency, new inputs not visible before the edge
        @(negedge clk);
        drive(VECS[0]);
        #1;
        check("R9 latency hold", dest_o[39:32], 8'hC0 ^ 8'd4);
        @(negedge clk);
        check("R9 latency update", dest_o[39:32], 8'h10 + 8'd4);

        // R9: mid-run reset clears outputs
        rst_n = 1'b0;
        #1;
        check("R9 async clear", dest_o, '0);
        check("R9 async clear supp", LW'(err_supp_o), '0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule